// File: doc/BRIEF.md
# DDR Mode Register Load Sequencer

This block sits on the controller side of a DDR SDRAM interface and programs the device's base mode register and extended mode register. A host asks for a programming sequence with a one-cycle `start` pulse. With that pulse it supplies the burst length and burst ordering, a CAS latency choice, a flag that marks a fast clock (133 to 200 MHz), DLL enable and reduced output drive. The sequencer then drives LOAD MODE REGISTER commands on the command/address pins. It inserts NOP cycles between commands and leaves `ready` low until the whole chain is done.

Every sequence first writes the extended register. That write waits until all banks are idle and no burst is running. If the DLL is being enabled, a base-register write with the DLL-reset bit follows, and then a normal-mode write with the same latency and burst settings. If the DLL is off, the normal-mode write follows the extended write directly. After any DLL enable, `read_ok` stays low until enough clock cycles with CKE high have passed. A requested latency that the clock class does not allow is refused.

Top module: `ddr_mrs_sequencer`

## Requirements
- R1: A normal-mode write drives LMR (`cs_n`,`ras_n`,`cas_n`,`we_n` all 0) with `ba`=00 and `addr`[12:7]=0. It carries the burst length on `addr`[2:0], interleaved ordering on `addr`[3], and the latency code on `addr`[6:4]: 010 for CL2 (select 0), 110 for CL2.5 (select 1), 011 for CL3 (select 2).
- R2: A DLL-reset write equals the normal-mode word plus `addr`[8]=1. The next LMR after it is a normal-mode write with identical `addr`[6:0].
- R3: Each accepted sequence starts with an extended-register write: `ba`=01, `addr`[0]=1 when the DLL is disabled, `addr`[1]=1 for reduced drive, all other address bits 0.
- R4: When the extended write enables the DLL, the next LMR is the DLL-reset write, so the sequence has 3 LMRs. With the DLL disabled, the sequence is the extended write then the normal-mode write (2 LMRs).
- R5: The extended write is driven only in the cycle after a rising edge at which `banks_idle`=1 and `burst_active`=0. Until then the block holds NOP.
- R6: Consecutive LMRs are at least `TMRD` cycles apart (default 2). Every non-LMR cycle carries NOP: `cs_n`=0, `ras_n`=`cas_n`=`we_n`=1, `ba`=0, `addr`=0.
- R7: After a DLL-enabling extended write, `read_ok` rises only after `LOCK_CYCLES` (default 200) consecutive rising edges with `cke`=1. A low `cke` restarts the count. Every extended write clears `read_ok`, and it stays low while the DLL is disabled.
- R8: A `start` with latency select 3, or with CL3 (select 2) while `cfg_freq_hi`=0, is ignored: no command is issued and `ready` stays high. CL3 with `cfg_freq_hi`=1 is accepted.
- R9: `ready` is high only when idle. `start` is taken only while `ready` is high. `ready` returns `TMRD`-1 cycles after the normal-mode write.
- R10: After reset the bus carries NOP, `ready`=1 and `read_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a programming sequence |
| cfg_burst_len | input | 3 | Burst length code for addr[2:0] |
| cfg_burst_interleave | input | 1 | Interleaved burst ordering |
| cfg_cas_sel | input | 2 | 0=CL2, 1=CL2.5, 2=CL3, 3=invalid |
| cfg_freq_hi | input | 1 | Clock is in the 133 to 200 MHz class |
| cfg_dll_en | input | 1 | Enable the DLL |
| cfg_drv_reduced | input | 1 | Select reduced output drive |
| banks_idle | input | 1 | All banks precharged |
| burst_active | input | 1 | A burst is in progress |
| cke | input | 1 | Clock enable level on the device |
| cs_n | output | 1 | Chip select |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address / mode word |
| ready | output | 1 | Sequencer idle, accepts start |
| read_ok | output | 1 | READ commands allowed |

## Verification
All command-bus outputs are registered. A command decided at a rising edge is therefore visible from that edge until the next one. `ready` changes at the edge that accepts `start` and at the edge that ends the final gap. `read_ok` rises at the `LOCK_CYCLES`-th CKE-high edge after the extended write. The bench steps a behavioural model at each rising edge, using the same input values the design samples there, and compares bus, `ready` and `read_ok` at the following falling edge. Inputs change only at falling edges, so no comparison depends on process order at the clock edge.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_EMR     = 3'd1,
    ST_GAP     = 3'd2,
    ST_MR_RST  = 3'd3,
    ST_MR_NORM = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_NOP = cmd_pins_t'(4'b0111);
  localparam cmd_pins_t CMD_LMR = cmd_pins_t'(4'b0000);

  localparam logic [1:0] CAS_SEL_2   = 2'd0;
  localparam logic [1:0] CAS_SEL_2P5 = 2'd1;
  localparam logic [1:0] CAS_SEL_3   = 2'd2;

  function automatic logic [2:0] cas_code(input logic [1:0] sel);
    case (sel)
      CAS_SEL_2:   cas_code = 3'b010;
      CAS_SEL_2P5: cas_code = 3'b110;
      CAS_SEL_3:   cas_code = 3'b011;
      default:     cas_code = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/ddr_mrs_word_build.sv
module ddr_mrs_word_build
  import ddr_mrs_pkg::*;
(
  input  logic [2:0] burst_len,
  input  logic       burst_interleave,
  input  logic [1:0] cas_sel,
  input  logic       freq_hi,
  input  logic       dll_en,
  input  logic       drv_reduced,
  output logic       legal,
  output logic [6:0] mr_low,
  output logic [1:0] emr_low
);

  logic sel_valid;
  logic speed_ok;

  always_comb begin
    sel_valid = (cas_sel != 2'd3);
    speed_ok  = (cas_sel != CAS_SEL_3) || freq_hi;
    legal     = sel_valid && speed_ok;
    mr_low    = {cas_code(cas_sel), burst_interleave, burst_len};
    emr_low   = {drv_reduced, ~dll_en};
  end

endmodule

// File: rtl/ddr_mrs_seq_fsm.sv
module ddr_mrs_seq_fsm
  import ddr_mrs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int TMRD   = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              legal,
  input  logic [6:0]        mr_low_in,
  input  logic [1:0]        emr_low_in,
  input  logic              dll_en_in,
  input  logic              banks_idle,
  input  logic              burst_active,
  output cmd_pins_t         cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic              emr_fire,
  output logic              emr_dll_on
);

  localparam int GAP_W = $clog2(TMRD + 1);
  localparam logic [GAP_W-1:0] GAP_INIT = GAP_W'(TMRD - 1);
  localparam logic [GAP_W-1:0] GAP_ONE  = GAP_W'(1);
  localparam logic [BA_W-1:0]  BA_EMR   = BA_W'(1);

  seq_state_e        state_q, state_d, after_q, after_d, follow;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [6:0]        mr_low_q;
  logic [1:0]        emr_low_q;
  logic              dll_q;
  logic              cfg_ld;
  logic              issue;
  cmd_pins_t         cmd_d, cmd_q;
  logic [BA_W-1:0]   ba_d, ba_q;
  logic [ADDR_W-1:0] addr_d, addr_q;

  function automatic logic [ADDR_W-1:0] mr_word(input logic [6:0] low, input logic dll_rst);
    mr_word      = '0;
    mr_word[6:0] = low;
    mr_word[8]   = dll_rst;
  endfunction

  function automatic logic [ADDR_W-1:0] emr_word(input logic [1:0] low);
    emr_word      = '0;
    emr_word[1:0] = low;
  endfunction

  // next-state and command decode
  always_comb begin
    state_d  = state_q;
    gap_d    = gap_q;
    after_d  = after_q;
    cfg_ld   = 1'b0;
    issue    = 1'b0;
    follow   = ST_IDLE;
    emr_fire = 1'b0;
    cmd_d    = CMD_NOP;
    ba_d     = '0;
    addr_d   = '0;
    case (state_q)
      ST_IDLE: begin
        if (start && legal) begin
          cfg_ld  = 1'b1;
          state_d = ST_EMR;
        end
      end
      ST_EMR: begin
        if (banks_idle && !burst_active) begin
          issue    = 1'b1;
          emr_fire = 1'b1;
          ba_d     = BA_EMR;
          addr_d   = emr_word(emr_low_q);
          follow   = dll_q ? ST_MR_RST : ST_MR_NORM;
        end
      end
      ST_MR_RST: begin
        issue  = 1'b1;
        addr_d = mr_word(mr_low_q, 1'b1);
        follow = ST_MR_NORM;
      end
      ST_MR_NORM: begin
        issue  = 1'b1;
        addr_d = mr_word(mr_low_q, 1'b0);
        follow = ST_IDLE;
      end
      ST_GAP: begin
        if (gap_q <= GAP_ONE) state_d = after_q;
        else                  gap_d   = gap_q - GAP_ONE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (issue) begin
      cmd_d   = CMD_LMR;
      after_d = follow;
      gap_d   = GAP_INIT;
      state_d = (TMRD > 1) ? ST_GAP : follow;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      after_q <= ST_IDLE;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      after_q <= after_d;
      gap_q   <= gap_d;
    end
  end

  // request capture, enabled at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_low_q  <= '0;
      emr_low_q <= '0;
      dll_q     <= 1'b0;
    end else if (cfg_ld) begin
      mr_low_q  <= mr_low_in;
      emr_low_q <= emr_low_in;
      dll_q     <= dll_en_in;
    end
  end

  // registered command/address bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
    end
  end

  assign cmd        = cmd_q;
  assign ba         = ba_q;
  assign addr       = addr_q;
  assign ready      = (state_q == ST_IDLE);
  assign emr_dll_on = emr_fire && dll_q;

endmodule

// File: rtl/ddr_mrs_dll_lock.sv
module ddr_mrs_dll_lock #(
  parameter int LOCK_CYCLES = 200
)(
  input  logic clk,
  input  logic rst_n,
  input  logic emr_fire,
  input  logic emr_dll_on,
  input  logic cke,
  output logic read_ok
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             on_q, on_d;
  logic             ok_q, ok_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    on_d  = on_q;
    ok_d  = ok_q;
    cnt_d = cnt_q;
    if (emr_fire) begin
      on_d  = emr_dll_on;
      ok_d  = 1'b0;
      cnt_d = '0;
    end else if (on_q && !ok_q) begin
      if (cke) begin
        cnt_d = cnt_q + CNT_ONE;
        if (cnt_q == CNT_LAST) ok_d = 1'b1;
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      ok_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      on_q  <= on_d;
      ok_q  <= ok_d;
      cnt_q <= cnt_d;
    end
  end

  assign read_ok = ok_q;

endmodule

// File: rtl/ddr_mrs_sequencer.sv
module ddr_mrs_sequencer
  import ddr_mrs_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int TMRD        = 2,
  parameter int LOCK_CYCLES = 200
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_interleave,
  input  logic [1:0]        cfg_cas_sel,
  input  logic              cfg_freq_hi,
  input  logic              cfg_dll_en,
  input  logic              cfg_drv_reduced,
  input  logic              banks_idle,
  input  logic              burst_active,
  input  logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic              read_ok
);

  logic       legal;
  logic [6:0] mr_low;
  logic [1:0] emr_low;
  logic       emr_fire;
  logic       emr_dll_on;
  cmd_pins_t  cmd;

  ddr_mrs_word_build u_words (
    .burst_len        (cfg_burst_len),
    .burst_interleave (cfg_burst_interleave),
    .cas_sel          (cfg_cas_sel),
    .freq_hi          (cfg_freq_hi),
    .dll_en           (cfg_dll_en),
    .drv_reduced      (cfg_drv_reduced),
    .legal            (legal),
    .mr_low           (mr_low),
    .emr_low          (emr_low)
  );

  ddr_mrs_seq_fsm #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .TMRD   (TMRD)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .legal        (legal),
    .mr_low_in    (mr_low),
    .emr_low_in   (emr_low),
    .dll_en_in    (cfg_dll_en),
    .banks_idle   (banks_idle),
    .burst_active (burst_active),
    .cmd          (cmd),
    .ba           (ba),
    .addr         (addr),
    .ready        (ready),
    .emr_fire     (emr_fire),
    .emr_dll_on   (emr_dll_on)
  );

  ddr_mrs_dll_lock #(
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .emr_fire   (emr_fire),
    .emr_dll_on (emr_dll_on),
    .cke        (cke),
    .read_ok    (read_ok)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;

endmodule

// File: rtl/ddr_mrs_sequencer_checker.sv
module ddr_mrs_sequencer_checker #(
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int TMRD        = 2,
  parameter int LOCK_CYCLES = 200
)(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        cfg_cas_sel,
  input logic              cfg_freq_hi,
  input logic              banks_idle,
  input logic              burst_active,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              ready,
  input logic              read_ok
);

  localparam int SW = $clog2(TMRD + 1) + 1;
  localparam int LW = $clog2(LOCK_CYCLES + 1) + 1;

  logic is_lmr, is_emr, is_mr, is_nop, illegal;
  logic [SW-1:0] since_q;
  logic [LW-1:0] lock_q;
  logic          pend_rst_q, pend_norm_q;
  logic [6:0]    pend_bits_q;

  assign is_lmr  = !cs_n && !ras_n && !cas_n && !we_n;
  assign is_nop  = !cs_n && ras_n && cas_n && we_n && (ba == '0) && (addr == '0);
  assign is_emr  = is_lmr && (ba == BA_W'(1));
  assign is_mr   = is_lmr && (ba == '0);
  assign illegal = (cfg_cas_sel == 2'd3) || ((cfg_cas_sel == 2'd2) && !cfg_freq_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q     <= SW'(TMRD);
      lock_q      <= '0;
      pend_rst_q  <= 1'b0;
      pend_norm_q <= 1'b0;
      pend_bits_q <= '0;
    end else begin
      if (is_lmr)                since_q <= SW'(1);
      else if (since_q < SW'(TMRD)) since_q <= since_q + SW'(1);
      if (is_emr)                lock_q <= cke ? LW'(1) : '0;
      else if (!cke)             lock_q <= '0;
      else if (lock_q < LW'(LOCK_CYCLES)) lock_q <= lock_q + LW'(1);
      if (is_lmr) begin
        pend_rst_q  <= is_emr && !addr[0];
        pend_norm_q <= is_mr && addr[8];
        pend_bits_q <= addr[6:0];
      end
    end
  end

  assert_reserved_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_mr |-> (addr[ADDR_W-1:7] == '0) || (addr[ADDR_W-1:7] == (ADDR_W-7)'(2)));

  assert_norm_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lmr && pend_norm_q) |-> (is_mr && (addr[ADDR_W-1:7] == '0) && (addr[6:0] == pend_bits_q)));

  assert_emr_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_emr |-> (addr[ADDR_W-1:2] == '0));

  assert_reset_after_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lmr && pend_rst_q) |-> (is_mr && addr[8]));

  assert_emr_banks_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_emr |-> $past(banks_idle && !burst_active));

  assert_lmr_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_lmr |-> (since_q >= SW'(TMRD)));

  assert_nop_filler_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_lmr |-> is_nop);

  assert_read_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_ok) |-> (lock_q >= LW'(LOCK_CYCLES)));

  assert_emr_clears_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_emr |-> !read_ok);

  assert_illegal_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start && illegal) |=> ready);

  assert_busy_while_lmr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_lmr |-> !ready);

endmodule

bind ddr_mrs_sequencer ddr_mrs_sequencer_checker #(
  .ADDR_W      (ADDR_W),
  .BA_W        (BA_W),
  .TMRD        (TMRD),
  .LOCK_CYCLES (LOCK_CYCLES)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .cfg_cas_sel  (cfg_cas_sel),
  .cfg_freq_hi  (cfg_freq_hi),
  .banks_idle   (banks_idle),
  .burst_active (burst_active),
  .cke          (cke),
  .cs_n         (cs_n),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n),
  .ba           (ba),
  .addr         (addr),
  .ready        (ready),
  .read_ok      (read_ok)
);

// File: tb/ddr_mrs_sequencer_bench.sv
`timescale 1ns/1ps
module ddr_mrs_sequencer_bench;

  localparam int AW   = 13;
  localparam int BW   = 2;
  localparam int TMRD = 2;
  localparam int LOCK = 200;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] cfg_burst_len = 3'd0;
  logic cfg_burst_interleave = 1'b0;
  logic [1:0] cfg_cas_sel = 2'd0;
  logic cfg_freq_hi = 1'b0, cfg_dll_en = 1'b0, cfg_drv_reduced = 1'b0;
  logic banks_idle = 1'b1, burst_active = 1'b0, cke = 1'b1;
  logic cs_n, ras_n, cas_n, we_n, ready, read_ok;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  ddr_mrs_sequencer #(.ADDR_W(AW), .BA_W(BW), .TMRD(TMRD), .LOCK_CYCLES(LOCK)) u_ddr_mrs_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_burst_len(cfg_burst_len),
    .cfg_burst_interleave(cfg_burst_interleave), .cfg_cas_sel(cfg_cas_sel),
    .cfg_freq_hi(cfg_freq_hi), .cfg_dll_en(cfg_dll_en), .cfg_drv_reduced(cfg_drv_reduced),
    .banks_idle(banks_idle), .burst_active(burst_active), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .ready(ready), .read_ok(read_ok));

  int n_tests = 0, n_fail = 0;
  bit live = 1'b0;

  task automatic check(input string req, input longint act, input longint exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_busy, m_dll, m_drv, m_lk_on;
  int       m_phase, m_gap, m_lk_cnt;
  bit [6:0] m_low;
  bit       e_lmr, e_rdok;
  bit [1:0] e_ba;
  bit [AW-1:0] e_addr;

  function automatic bit [2:0] lat_code(input bit [1:0] s);
    if (s == 2'd0) return 3'b010;
    if (s == 2'd1) return 3'b110;
    return 3'b011;
  endfunction

  function automatic bit req_ok(input bit [1:0] s, input bit hi);
    if (s == 2'd3) return 1'b0;
    if (s == 2'd2 && !hi) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    bit fire;
    fire = 1'b0;
    if (!rst_n) begin
      m_busy = 0; m_phase = 0; m_gap = 0; m_lk_on = 0; m_lk_cnt = 0;
      e_lmr = 0; e_ba = 0; e_addr = 0; e_rdok = 0;
    end else begin
      e_lmr = 0; e_ba = 0; e_addr = 0;
      if (!m_busy) begin
        if (start && req_ok(cfg_cas_sel, cfg_freq_hi)) begin
          m_busy = 1; m_phase = 0; m_gap = 0;
          m_low = {lat_code(cfg_cas_sel), cfg_burst_interleave, cfg_burst_len};
          m_dll = cfg_dll_en; m_drv = cfg_drv_reduced;
        end
      end else if (m_gap > 0) begin
        m_gap--;
        if (m_gap == 0 && m_phase == 3) m_busy = 0;
      end else begin
        if (m_phase == 0) begin
          if (banks_idle && !burst_active) begin
            e_lmr = 1; e_ba = 2'b01; e_addr = {11'd0, m_drv, !m_dll};
            fire = 1; m_phase = m_dll ? 1 : 2; m_gap = TMRD - 1;
          end
        end else if (m_phase == 1) begin
          e_lmr = 1; e_addr = {4'd0, 1'b1, 1'b0, m_low}; m_phase = 2; m_gap = TMRD - 1;
        end else if (m_phase == 2) begin
          e_lmr = 1; e_addr = {6'd0, m_low}; m_phase = 3; m_gap = TMRD - 1;
          if (m_gap == 0) m_busy = 0;
        end
      end
      if (fire) begin
        m_lk_on = m_dll; m_lk_cnt = 0; e_rdok = 0;
      end else if (m_lk_on && !e_rdok) begin
        if (cke) begin
          m_lk_cnt++;
          if (m_lk_cnt == LOCK) e_rdok = 1;
        end else m_lk_cnt = 0;
      end
    end
  end

  int lmr_seen = 0;
  always @(negedge clk) begin
    if (live && rst_n) begin
      string tag;
      if (!e_lmr) tag = "R6";
      else if (e_ba == 2'b01) tag = "R3";
      else if (e_addr[8]) tag = "R2";
      else tag = "R1";
      check(tag, {cs_n, ras_n, cas_n, we_n, ba, addr},
            {1'b0, {3{!e_lmr}}, e_ba, e_addr}, "command bus");
      check("R9", ready, !m_busy, "ready");
      check("R7", read_ok, e_rdok, "read_ok");
      if (!cs_n && !ras_n && !cas_n && !we_n) lmr_seen++;
    end
  end

  task automatic request(input bit [2:0] bl, input bit il, input bit [1:0] cl,
                         input bit hi, input bit dll, input bit drv);
    cfg_burst_len = bl; cfg_burst_interleave = il; cfg_cas_sel = cl;
    cfg_freq_hi = hi; cfg_dll_en = dll; cfg_drv_reduced = drv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    live  = 1'b1;
    // R10: reset state
    check("R10", ready, 1, "ready after reset");
    check("R10", read_ok, 0, "read_ok after reset");
    check("R10", {cs_n, ras_n, cas_n, we_n}, 4'b0111, "NOP after reset");
    idle(2);

    // R4: DLL-enable chain, CL2.5, reduced drive
    base = lmr_seen;
    request(3'b010, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1);
    idle(12);
    check("R4", lmr_seen - base, 3, "LMR count with DLL enabled");

    // R7: CKE drop restarts lock count
    idle(80);
    cke = 1'b0; idle(3); cke = 1'b1;
    idle(150);
    check("R7", read_ok, 0, "read_ok still low after CKE drop");
    idle(60);
    check("R7", read_ok, 1, "read_ok after full lock window");

    // R5: bank busy and burst active hold the extended write; DLL off path
    base = lmr_seen;
    banks_idle = 1'b0;
    request(3'b011, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
    idle(5);
    banks_idle = 1'b1; burst_active = 1'b1;
    idle(4);
    check("R5", lmr_seen - base, 0, "no LMR while banks busy");
    burst_active = 1'b0;
    idle(10);
    check("R4", lmr_seen - base, 2, "LMR count with DLL disabled");
    check("R7", read_ok, 0, "read_ok low with DLL disabled");

    // R8: illegal latency requests ignored
    base = lmr_seen;
    request(3'b001, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0);
    idle(6);
    check("R8", ready, 1, "CL3 at low clock ignored");
    request(3'b001, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0);
    idle(6);
    check("R8", lmr_seen - base, 0, "invalid latency ignored");

    // R8/R9: CL3 at high clock accepted; start during busy ignored
    request(3'b001, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0);
    check("R9", ready, 0, "busy after accepted start");
    request(3'b111, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
    idle(10);
    check("R8", lmr_seen - base, 3, "CL3 at high clock accepted");

    // R7: DLL-off write after a lock clears read_ok
    idle(210);
    check("R7", read_ok, 1, "read_ok after second lock");
    request(3'b010, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    idle(4);
    check("R7", read_ok, 0, "read_ok cleared by extended write");
    idle(6);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule